// File: doc/BRIEF.md
# Dual-Slot PCM Codec Serial Port

This block moves PCM samples between a processing core and one or two codecs that share a single serial data-in and data-out pair. Each frame holds two time slots that follow one another. A primary frame sync marks the first slot. A secondary sync output, raised once the first slot's last bit has gone by, marks the second slot. In master mode the port makes the bit clock from the system clock with a programmable divider, and it also makes the primary sync. In slave mode it takes both from outside. A slave may also ask for the incoming bit clock to be halved before it is used.

The core side is parallel. Two transmit words are taken when a frame starts. When a frame ends, the two received words appear on holding outputs together with a one-cycle strobe. All logic runs on the system clock. Bit-clock edges appear internally as one-cycle rise and fall events.

Top module: `pcm_dual_slot_port`

## Requirements
- R1: During and straight after reset, bclk_o, fs0_o, fs1_o, dout, frame_done, rx0 and rx1 are all zero.
- R2: Short format (cfg_long=0). fs0 is high for the single bit period at position 0. Slot 0 fills positions 1 to W. fs1 is high only at position W+1. Slot 1 fills positions W+2 to 2W+1.
- R3: Long format (cfg_long=1). fs0 is high for positions 0 to W-1, together with slot 0. fs1 is high for positions W to 2W-1, together with slot 1.
- R4: Each slot is sent most significant bit first. dout changes only at an internal bit-clock rising event. din is sampled at the falling event of each slot period.
- R5: W is 16 when cfg_wide=1 and 8 otherwise. In 8-bit mode only bits [7:0] of tx0 and tx1 are sent, and bits [15:8] of rx0 and rx1 read zero.
- R6: In master mode the bclk_o period is 2*cfg_half_div system clocks, and a frame lasts cfg_frame_len bit periods.
- R7: In slave mode bclk_oe and fs0_oe are low. A frame starts when fs0_i is first found high at a falling bit-clock event after being low, and that bit period is position 0. The frame stops after slot 1 until the next such start.
- R8: In slave mode with cfg_dbl=1, the internal bit clock is bclk_i divided by two. Its rising event follows the 1st, 3rd, 5th... rising edge of bclk_i after reset, and its falling event follows the even-numbered ones.
- R9: In the system cycle after the last bit of slot 1 is sampled, frame_done is high for exactly one cycle, and rx0 and rx1 hold the words received in slots 0 and 1.
- R10: tx0 and tx1 are captured at the start of a frame. Changing them during a frame has no effect on dout until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_master | input | 1 | 1: port drives bit clock and primary sync |
| cfg_long | input | 1 | 1: long sync format, 0: short |
| cfg_wide | input | 1 | 1: 16-bit slots, 0: 8-bit slots |
| cfg_dbl | input | 1 | Slave only: halve the incoming bit clock |
| cfg_half_div | input | DIV_W | Master bit-clock half period in system clocks |
| cfg_frame_len | input | 8 | Master frame length in bit periods |
| bclk_i | input | 1 | Bit clock input (slave) |
| bclk_o | output | 1 | Bit clock output (master) |
| bclk_oe | output | 1 | Drive enable for bclk_o |
| fs0_i | input | 1 | Primary sync input (slave) |
| fs0_o | output | 1 | Primary sync output (master) |
| fs0_oe | output | 1 | Drive enable for fs0_o |
| fs1_o | output | 1 | Secondary sync, second slot marker |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| tx0 | input | 16 | Transmit word, slot 0 |
| tx1 | input | 16 | Transmit word, slot 1 |
| rx0 | output | 16 | Received word, slot 0 |
| rx1 | output | 16 | Received word, slot 1 |
| frame_done | output | 1 | One-cycle end-of-frame strobe |

## Verification
The bench covers the places where the two sync formats lay out a frame differently. If the lead-in period of the short format is dropped, every slot 0 bit lands one position early. If fs1 is placed at W instead of W+1, the second codec's data is misframed. It changes tx words in the middle of a frame. A port that does not hold a copy of the words would then mix old and new bits in one slot. In 8-bit mode it drives receive words whose upper byte is nonzero, to expose stale shift-register bits. In slave double-rate mode a wrong divider phase would swap the sampling and launch edges, and every received word would be wrong.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  localparam int WORD_W = 16;
  localparam int POS_W  = 8;

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic pos_t slot_len(input logic wide);
    return wide ? pos_t'(16) : pos_t'(8);
  endfunction

  // first bit position of slot 0 (second=0) or slot 1 (second=1)
  function automatic pos_t slot_start(input logic second, input logic long_fmt, input pos_t w);
    if (!second) return long_fmt ? pos_t'(0) : pos_t'(1);
    return long_fmt ? w : w + pos_t'(2);
  endfunction

  function automatic logic in_window(input pos_t q, input pos_t base, input pos_t w);
    return (q >= base) && (q < base + w);
  endfunction

  function automatic pos_t final_pos(input logic long_fmt, input pos_t w);
    return slot_start(1'b1, long_fmt, w) + w - pos_t'(1);
  endfunction

  function automatic logic fs0_on(input pos_t q, input logic long_fmt, input pos_t w);
    return long_fmt ? (q < w) : (q == pos_t'(0));
  endfunction

  function automatic logic fs1_on(input pos_t q, input logic long_fmt, input pos_t w);
    return long_fmt ? in_window(q, w, w) : (q == w + pos_t'(1));
  endfunction

  function automatic logic msb_of(input word_t v, input pos_t w);
    pos_t idx;
    idx = w - pos_t'(1);
    return v[idx[3:0]];
  endfunction

  // serial bit sent in bit period q
  function automatic logic tx_bit(input pos_t q, input logic long_fmt, input pos_t w,
                                  input word_t t0, input word_t t1);
    pos_t b0;
    pos_t b1;
    pos_t idx;
    b0 = slot_start(1'b0, long_fmt, w);
    b1 = slot_start(1'b1, long_fmt, w);
    if (in_window(q, b0, w)) begin
      idx = b0 + w - pos_t'(1) - q;
      return t0[idx[3:0]];
    end
    if (in_window(q, b1, w)) begin
      idx = b1 + w - pos_t'(1) - q;
      return t1[idx[3:0]];
    end
    return 1'b0;
  endfunction

  function automatic word_t mask_word(input word_t v, input logic wide);
    return wide ? v : {8'h00, v[7:0]};
  endfunction

endpackage

// File: rtl/pcm_bit_timer.sv
module pcm_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             dbl,
  input  logic [DIV_W-1:0] half_div,
  input  logic             bclk_in,
  input  logic             fs0_in,
  output logic             bclk_out,
  output logic             fs0_sync,
  output logic             rise_ev,
  output logic             fall_ev
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_lim;
  logic             bclk_r;
  logic             tick;
  logic [2:0]       bsync;
  logic [1:0]       fsync;
  logic             half_q;
  logic             ext_rise;
  logic             ext_fall;

  assign half_lim = (half_div == '0) ? DIV_W'(1) : half_div;
  assign tick     = master && (cnt >= half_lim - DIV_W'(1));
  assign ext_rise = bsync[1] & ~bsync[2];
  assign ext_fall = ~bsync[1] & bsync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      bclk_r <= 1'b0;
      bsync  <= '0;
      fsync  <= '0;
      half_q <= 1'b0;
    end else begin
      if (master) begin
        if (tick) begin
          cnt    <= '0;
          bclk_r <= ~bclk_r;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end else begin
        cnt    <= '0;
        bclk_r <= 1'b0;
      end
      bsync <= {bsync[1:0], bclk_in};
      fsync <= {fsync[0], fs0_in};
      if (!master && dbl && ext_rise) half_q <= ~half_q;
    end
  end

  always_comb begin
    if (master) begin
      rise_ev = tick & ~bclk_r;
      fall_ev = tick & bclk_r;
    end else if (dbl) begin
      rise_ev = ext_rise & ~half_q;
      fall_ev = ext_rise & half_q;
    end else begin
      rise_ev = ext_rise;
      fall_ev = ext_fall;
    end
  end

  assign bclk_out = bclk_r;
  assign fs0_sync = fsync[1];

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_ev && fall_ev)); // R4

endmodule

// File: rtl/pcm_slot_seq.sv
module pcm_slot_seq
  import pcm_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  master,
  input  logic  long_fmt,
  input  logic  wide,
  input  pos_t  frame_len,
  input  logic  rise_ev,
  input  logic  fall_ev,
  input  logic  fs0_in,
  input  logic  din,
  input  word_t tx0,
  input  word_t tx1,
  output logic  fs0_o,
  output logic  fs1_o,
  output logic  dout_o,
  output word_t rx0,
  output word_t rx1,
  output logic  frame_done
);

  pos_t  pos;
  pos_t  w;
  pos_t  lastp;
  pos_t  b0;
  pos_t  b1;
  pos_t  cur;
  pos_t  nxt_m;
  pos_t  nxt_s;
  logic  active;
  logic  fs_prev;
  logic  start_hit;
  logic  take_bit;
  word_t tx0_q, tx1_q;
  word_t src0, src1;
  word_t sh0, sh1;
  word_t rx0_q, rx1_q;
  logic  done_q;
  logic  fs0_r, fs1_r, dout_r;

  assign w         = slot_len(wide);
  assign lastp     = final_pos(long_fmt, w);
  assign b0        = slot_start(1'b0, long_fmt, w);
  assign b1        = slot_start(1'b1, long_fmt, w);
  assign start_hit = !master && fall_ev && fs0_in && !fs_prev;
  assign cur       = start_hit ? pos_t'(0) : pos;
  assign nxt_m     = (pos >= frame_len - pos_t'(1)) ? pos_t'(0) : pos + pos_t'(1);
  assign nxt_s     = pos + pos_t'(1);
  assign take_bit  = fall_ev && (master || active || start_hit);
  assign src0      = (nxt_m == pos_t'(0)) ? tx0 : tx0_q;
  assign src1      = (nxt_m == pos_t'(0)) ? tx1 : tx1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '1;
      active  <= 1'b0;
      fs_prev <= 1'b0;
      tx0_q   <= '0;
      tx1_q   <= '0;
      sh0     <= '0;
      sh1     <= '0;
      rx0_q   <= '0;
      rx1_q   <= '0;
      done_q  <= 1'b0;
      fs0_r   <= 1'b0;
      fs1_r   <= 1'b0;
      dout_r  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rise_ev) begin
        if (master) begin
          pos    <= nxt_m;
          fs0_r  <= fs0_on(nxt_m, long_fmt, w);
          fs1_r  <= fs1_on(nxt_m, long_fmt, w);
          dout_r <= tx_bit(nxt_m, long_fmt, w, src0, src1);
          if (nxt_m == pos_t'(0)) begin
            tx0_q <= tx0;
            tx1_q <= tx1;
          end
        end else if (active && pos != lastp) begin
          pos    <= nxt_s;
          fs0_r  <= 1'b0;
          fs1_r  <= fs1_on(nxt_s, long_fmt, w);
          dout_r <= tx_bit(nxt_s, long_fmt, w, tx0_q, tx1_q);
        end else begin
          active <= 1'b0;
          fs0_r  <= 1'b0;
          fs1_r  <= 1'b0;
          dout_r <= long_fmt ? msb_of(tx0, w) : 1'b0;
        end
      end
      if (fall_ev) begin
        fs_prev <= fs0_in;
        if (start_hit) begin
          active <= 1'b1;
          pos    <= '0;
          tx0_q  <= tx0;
          tx1_q  <= tx1;
        end
      end
      if (take_bit) begin
        if (in_window(cur, b0, w)) sh0 <= {sh0[WORD_W-2:0], din};
        if (in_window(cur, b1, w)) sh1 <= {sh1[WORD_W-2:0], din};
        if (cur == lastp) begin
          rx0_q  <= mask_word(sh0, wide);
          rx1_q  <= mask_word({sh1[WORD_W-2:0], din}, wide);
          done_q <= 1'b1;
        end
      end
    end
  end

  assign fs0_o      = fs0_r;
  assign fs1_o      = fs1_r;
  assign dout_o     = dout_r;
  assign rx0        = rx0_q;
  assign rx1        = rx1_q;
  assign frame_done = done_q;

  AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_o) |-> $past(rise_ev)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R9
  AST_SHORT_FS0_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !long_fmt && fs0_o && rise_ev && frame_len > pos_t'(1)) |=> !fs0_o); // R2
  AST_FS1_CLEAR_OF_FS0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs1_o) |-> !fs0_o); // R3

endmodule

// File: rtl/pcm_dual_slot_port.sv
module pcm_dual_slot_port
  import pcm_port_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_long,
  input  logic             cfg_wide,
  input  logic             cfg_dbl,
  input  logic [DIV_W-1:0] cfg_half_div,
  input  logic [7:0]       cfg_frame_len,
  input  logic             bclk_i,
  output logic             bclk_o,
  output logic             bclk_oe,
  input  logic             fs0_i,
  output logic             fs0_o,
  output logic             fs0_oe,
  output logic             fs1_o,
  input  logic             din,
  output logic             dout,
  input  logic [15:0]      tx0,
  input  logic [15:0]      tx1,
  output logic [15:0]      rx0,
  output logic [15:0]      rx1,
  output logic             frame_done
);

  logic rise_ev;
  logic fall_ev;
  logic fs0_sync;

  pcm_bit_timer #(.DIV_W(DIV_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .master   (cfg_master),
    .dbl      (cfg_dbl),
    .half_div (cfg_half_div),
    .bclk_in  (bclk_i),
    .fs0_in   (fs0_i),
    .bclk_out (bclk_o),
    .fs0_sync (fs0_sync),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev)
  );

  pcm_slot_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .master     (cfg_master),
    .long_fmt   (cfg_long),
    .wide       (cfg_wide),
    .frame_len  (cfg_frame_len),
    .rise_ev    (rise_ev),
    .fall_ev    (fall_ev),
    .fs0_in     (fs0_sync),
    .din        (din),
    .tx0        (tx0),
    .tx1        (tx1),
    .fs0_o      (fs0_o),
    .fs1_o      (fs1_o),
    .dout_o     (dout),
    .rx0        (rx0),
    .rx1        (rx1),
    .frame_done (frame_done)
  );

  assign bclk_oe = cfg_master;
  assign fs0_oe  = cfg_master;

endmodule

// File: tb/test_pcm_dual_slot_port.sv
module test_pcm_dual_slot_port;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_long = 1'b0, cfg_wide = 1'b0, cfg_dbl = 1'b0;
  logic [7:0] cfg_half_div = 8'd2;
  logic [7:0] cfg_frame_len = 8'd20;
  logic bclk_i = 1'b0, fs0_i = 1'b0, din = 1'b0;
  logic [15:0] tx0 = '0, tx1 = '0;
  logic bclk_o, bclk_oe, fs0_o, fs0_oe, fs1_o, dout, frame_done;
  logic [15:0] rx0, rx1;

  pcm_dual_slot_port i_pcm_dual_slot_port (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_long(cfg_long),
    .cfg_wide(cfg_wide), .cfg_dbl(cfg_dbl), .cfg_half_div(cfg_half_div),
    .cfg_frame_len(cfg_frame_len), .bclk_i(bclk_i), .bclk_o(bclk_o),
    .bclk_oe(bclk_oe), .fs0_i(fs0_i), .fs0_o(fs0_o), .fs0_oe(fs0_oe),
    .fs1_o(fs1_o), .din(din), .dout(dout), .tx0(tx0), .tx1(tx1),
    .rx0(rx0), .rx1(rx1), .frame_done(frame_done)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  localparam int EXT_HALF = 200;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bench view of the frame: offset of a position inside each slot
  function automatic int offs(input int q, input bit second, input bit lf, input int w);
    int lead;
    lead = lf ? 0 : 1;
    if (second) lead = lead + w + (lf ? 0 : 1);
    return q - lead;
  endfunction

  function automatic bit ser_bit(input int q, input bit lf, input int w,
                                 input logic [15:0] a, input logic [15:0] b);
    int o;
    o = offs(q, 1'b0, lf, w);
    if (o >= 0 && o < w) return a[w-1-o];
    o = offs(q, 1'b1, lf, w);
    if (o >= 0 && o < w) return b[w-1-o];
    return 1'b0;
  endfunction

  function automatic bit want_fs0(input int q, input bit lf, input int w);
    if (lf) return q < w;
    return q == 0;
  endfunction

  function automatic bit want_fs1(input int q, input bit lf, input int w);
    if (lf) return (q >= w) && (q < 2 * w);
    return q == w + 1;
  endfunction

  function automatic logic [15:0] keep(input logic [15:0] v, input int w);
    return (w == 16) ? v : (v & 16'h00FF);
  endfunction

  task automatic do_reset(input bit m, input bit lf, input bit wd, input bit db,
                          input logic [7:0] half, input logic [7:0] flen);
    rst_n = 1'b0;
    cfg_master = m; cfg_long = lf; cfg_wide = wd; cfg_dbl = db;
    cfg_half_div = half; cfg_frame_len = flen;
    bclk_i = 1'b0; fs0_i = 1'b0; din = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic master_frame(input logic [15:0] t0, input logic [15:0] t1,
                              input logic [15:0] r0, input logic [15:0] r1,
                              input int change_at, input logic [15:0] n0,
                              input logic [15:0] n1);
    int w;
    int e_fs0, e_fs1, e_dout;
    bit prev;
    time t_first;
    w = cfg_wide ? 16 : 8;
    e_fs0 = 0; e_fs1 = 0; e_dout = 0;
    tx0 = t0; tx1 = t1;
    prev = fs0_o;
    forever begin
      @(posedge bclk_o); #1;
      if (fs0_o && !prev) break;
      prev = fs0_o;
    end
    t_first = $time;
    exp_q.push_back({keep(r1, w), keep(r0, w)});
    for (int q = 0; q < int'(cfg_frame_len); q++) begin
      if (q > 0) begin
        @(posedge bclk_o); #1;
      end
      if (q == 1)
        chk(($time - t_first) == time'(2 * cfg_half_div * 20), "R6", "bit period",
            32'($time - t_first), 32'(2 * cfg_half_div * 20));
      if (fs0_o != want_fs0(q, cfg_long, w)) e_fs0++;
      if (fs1_o != want_fs1(q, cfg_long, w)) e_fs1++;
      if (dout != ser_bit(q, cfg_long, w, t0, t1)) e_dout++;
      din = ser_bit(q, cfg_long, w, r0, r1);
      if (q == change_at) begin
        tx0 = n0; tx1 = n1;
      end
    end
    chk(e_fs0 == 0, cfg_long ? "R3" : "R2", "fs0 pattern errors", e_fs0, 0);
    chk(e_fs1 == 0, cfg_long ? "R3" : "R2", "fs1 pattern errors", e_fs1, 0);
    chk(e_dout == 0, change_at >= 0 ? "R10" : "R4", "dout bit errors", e_dout, 0);
    @(posedge bclk_o); #1;
    chk(fs0_o == 1'b1, "R6", "next frame starts after frame_len periods", fs0_o, 1);
  endtask

  task automatic slave_frame(input logic [15:0] t0, input logic [15:0] t1,
                             input logic [15:0] r0, input logic [15:0] r1);
    int w, nper, e_fs1, e_dout;
    string tag;
    w = cfg_wide ? 16 : 8;
    nper = cfg_long ? 2 * w : 2 * w + 2;
    e_fs1 = 0; e_dout = 0;
    tag = cfg_dbl ? "R8" : "R7";
    tx0 = t0; tx1 = t1;
    exp_q.push_back({keep(r1, w), keep(r0, w)});
    @(negedge clk);
    for (int q = 0; q < nper + 2; q++) begin
      bclk_i = 1'b1;
      fs0_i = (q < nper) ? want_fs0(q, cfg_long, w) : 1'b0;
      din   = (q < nper) ? ser_bit(q, cfg_long, w, r0, r1) : 1'b0;
      #EXT_HALF bclk_i = 1'b0;
      #EXT_HALF;
      if (cfg_dbl) begin
        bclk_i = 1'b1;
        #EXT_HALF bclk_i = 1'b0;
        #EXT_HALF;
      end
      if (q < nper) begin
        if (fs1_o != want_fs1(q, cfg_long, w)) e_fs1++;
        if (dout != ser_bit(q, cfg_long, w, t0, t1)) e_dout++;
      end
    end
    chk(e_fs1 == 0, tag, "slave fs1 errors", e_fs1, 0);
    chk(e_dout == 0, tag, "slave dout errors", e_dout, 0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (frame_done && exp_q.size() > 0) begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk({rx1, rx0} == e, "R9", "received words at frame_done", {rx1, rx0}, e);
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // master, short, 8-bit
    do_reset(1, 0, 0, 0, 8'd2, 8'd20);
    #1;
    chk({bclk_o, fs0_o, fs1_o, dout, frame_done} == 5'b0, "R1", "serial outputs after reset",
        {bclk_o, fs0_o, fs1_o, dout, frame_done}, 0);
    chk({rx1, rx0} == 32'h0, "R1", "rx words after reset", {rx1, rx0}, 0);
    chk(bclk_oe && fs0_oe, "R6", "master drives clock and sync", {bclk_oe, fs0_oe}, 2'b11);
    master_frame(16'h12A5, 16'h003C, 16'hFF96, 16'hAB71, -1, 0, 0);
    chk(rx0[15:8] == 8'h00 && rx1[15:8] == 8'h00, "R5", "upper byte zero in 8-bit",
        {rx1[15:8], rx0[15:8]}, 0);
    master_frame(16'h0081, 16'h00FE, 16'h0001, 16'h0080, -1, 0, 0);

    // master, short, 16-bit, mid-frame tx change
    do_reset(1, 0, 1, 0, 8'd3, 8'd34);
    master_frame(16'hC3A1, 16'h5E0F, 16'h8001, 16'h7FFE, 3, 16'h1234, 16'hFEDC);
    master_frame(16'h1234, 16'hFEDC, 16'hBEEF, 16'hCAFE, -1, 0, 0);

    // master, long, 16-bit and 8-bit
    do_reset(1, 1, 1, 0, 8'd1, 8'd32);
    master_frame(16'hA55A, 16'h0FF0, 16'h1357, 16'h2468, -1, 0, 0);
    do_reset(1, 1, 0, 0, 8'd2, 8'd24);
    master_frame(16'h00C6, 16'h0039, 16'hF00D, 16'h0E71, -1, 0, 0);

    // slave, short 16-bit
    do_reset(0, 0, 1, 0, 8'd2, 8'd0);
    #1;
    chk(!bclk_oe && !fs0_oe, "R7", "slave releases clock and sync", {bclk_oe, fs0_oe}, 0);
    slave_frame(16'h9C3E, 16'h4411, 16'h6D2B, 16'hE817);
    slave_frame(16'h0001, 16'h8000, 16'hFFFF, 16'h0000);

    // slave, long 8-bit
    do_reset(0, 1, 0, 0, 8'd2, 8'd0);
    slave_frame(16'h00B4, 16'h004B, 16'h77C2, 16'h0119);

    // slave double rate, short 8-bit and long 16-bit
    do_reset(0, 0, 0, 1, 8'd2, 8'd0);
    slave_frame(16'h005A, 16'h00E1, 16'h003D, 16'h0092);
    do_reset(0, 1, 1, 1, 8'd2, 8'd0);
    slave_frame(16'hD00F, 16'h2BB4, 16'h1E87, 16'hF0C3);
    slave_frame(16'h7001, 16'h0E02, 16'h8421, 16'h1248);

    repeat (20) @(posedge clk);
    chk(exp_q.size() == 0, "R9", "every frame produced frame_done", exp_q.size(), 0);
    finish_run();
  end

endmodule